// File: doc/BRIEF.md
# Switchable-Order Sinc Decimator

This block turns the 1-bit stream of a delta-sigma modulator into signed multi-bit words. It takes one output word for every N accepted modulator samples, where N is set at run time. In its normal mode it applies a third-order sinc lowpass: three integrators run at the sample rate, and three differentiators run at the word rate. A fast-mode control switches it to a first-order sinc. That mode is a plain integrate-and-dump over N samples. It has the same notch positions at multiples of the word rate and settles in one word instead of three. A bypass control skips the filter and presents each raw modulator bit as a word of its own.

Samples arrive on a valid-only stream (`mod_valid`, `mod_bit`). A modulator cannot be stalled, so the input has no ready signal. Results leave on a valid/ready stream. `out_valid` rises with each new word and stays high, with `out_data` unchanged, until `out_ready` is seen high. If a new word is produced before the previous word is taken, the new word replaces it. With `out_ready` held high, `out_valid` is a one-cycle strobe per word.

Changing N or the fast-mode bit restarts the filter: all filter state is flushed and the word count starts again. Data-valid is then withheld until the active response order has seen enough complete words.

Top module: `sinc_decimator`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is all zeros.
- R2: Each word boundary falls on every N-th accepted sample (`mod_valid` high), counted from the last restart. Its word is registered at the same clock edge that takes that N-th sample. Values of `decim_n` below 2 act as 2.
- R3: In third-order mode, bit 1 counts as +1 and bit 0 as −1. The word equals sum over j of h[j]·x[t−j], where x[t] is the newest sample, h is the convolution of three length-N boxes (h[0]=1, length 3N−2), and samples before the last restart count as 0. A constant input gives ±N³.
- R4: In fast mode, the word equals N² times the sum of the N samples of that word. A constant input gives ±N³, the same full scale as R3.
- R5: A restart happens when N or the fast-mode bit differs from the value held at the previous edge (and also after reset). At the restart edge the sample is dropped, any partial word is discarded and `out_valid` clears. In third-order mode the first two words after a restart are not presented, and the third is.
- R6: In fast mode the first word after a restart is presented.
- R7: Within one word period after a restart into fast mode, a word is presented whose value depends only on the samples taken since that restart.
- R8: While `bypass` is 1 and no restart is pending, each accepted sample produces a word at the next edge: `out_data` carries the bit in bit 0 and zeros above it. No filter word is presented during this time, and the filter state keeps advancing so filtered words resume on the same boundaries.
- R9: An unread word keeps `out_valid` high and `out_data` stable until `out_ready` is high at an edge. A newer word overwrites an unread one.
- R10: Clock cycles with `mod_valid` low change neither the word position nor the filter result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_valid | input | 1 | Qualifies `mod_bit` as a sample this cycle |
| mod_bit | input | 1 | Modulator output bit |
| decim_n | input | NW | Decimation factor N |
| fast_mode | input | 1 | 1 selects the first-order response |
| bypass | input | 1 | 1 presents raw bits as words |
| out_valid | output | 1 | A word is waiting on `out_data` |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 1+3·NW | Signed output word |

## Verification
The bench builds the block with NW=6, so N can reach 63. At that value the full-scale words of ±250047 and a 187-tap weighting window are exercised within a few hundred cycles. It sweeps N from the minimum of 2 through odd, power-of-two and maximum values in both orders. Random gaps in `mod_valid` and random back-pressure on `out_ready` are mixed in. Directed runs cover restarts in the middle of a word, the three-word settle, the bypass path and overwriting of unread words.

// File: rtl/sinc_decim_pkg.sv
package sinc_decim_pkg;

  // Accumulator width that keeps a wrapping third-order chain exact.
  function automatic int acc_width(input int nw);
    return 1 + 3 * nw;
  endfunction

  // Which source feeds the output register on a given cycle.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SINC3 = 2'd1,
    SRC_SINC1 = 2'd2,
    SRC_RAW   = 2'd3
  } word_src_e;

  // Words needed after a restart before data may be presented.
  localparam int SETTLE_SINC3 = 3;
  localparam int SETTLE_SINC1 = 1;

endpackage

// File: rtl/sinc_word_timer.sv
module sinc_word_timer #(
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en,
  input  logic [NW-1:0] decim_n,
  input  logic          fast_mode,
  output logic [NW-1:0] n_act,
  output logic          fast_act,
  output logic          restart,
  output logic          dump,
  output logic          word_ok
);
  import sinc_decim_pkg::*;

  localparam logic [NW-1:0] N_MIN = NW'(2);
  localparam logic [1:0]    W_SAT = 2'(SETTLE_SINC3);

  logic [NW-1:0] n_eff;
  logic [NW-1:0] cnt_q;
  logic [1:0]    words_q;
  logic          fast_q;
  logic          last;

  assign n_eff    = (decim_n < N_MIN) ? N_MIN : decim_n;
  assign restart  = (n_eff != n_act) || (fast_mode != fast_q);
  assign last     = (cnt_q == (n_act - NW'(1)));
  assign dump     = sample_en && !restart && last;
  assign fast_act = fast_q;

  // The word being completed is number words_q+1 since the restart.
  assign word_ok = dump && (fast_q ? (words_q >= 2'(SETTLE_SINC1 - 1))
                                   : (words_q >= 2'(SETTLE_SINC3 - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_act   <= N_MIN;
      fast_q  <= 1'b0;
      cnt_q   <= '0;
      words_q <= '0;
    end else if (restart) begin
      n_act   <= n_eff;
      fast_q  <= fast_mode;
      cnt_q   <= '0;
      words_q <= '0;
    end else if (sample_en) begin
      if (last) begin
        cnt_q <= '0;
        if (words_q != W_SAT) words_q <= words_q + 2'd1;
      end else begin
        cnt_q <= cnt_q + NW'(1);
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < n_act) else $error("word position outside N"); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !restart) |=> ($stable(cnt_q) && $stable(words_q)))
    else $error("idle cycle moved word timing"); // R10

endmodule

// File: rtl/sinc3_core.sv
module sinc3_core #(
  parameter int AW = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 dump,
  input  logic                 x_bit,
  output logic signed [AW-1:0] word
);
  localparam int ORDER = 3;

  logic signed [AW-1:0] x;
  logic signed [AW-1:0] integ_q [ORDER];
  logic signed [AW-1:0] integ_n [ORDER];
  logic signed [AW-1:0] dly_q   [ORDER];
  logic signed [AW-1:0] comb_n  [ORDER];

  assign x = x_bit ? AW'(1) : -AW'(1);

  // Integrators at sample rate; differentiators evaluated on the dump sample.
  always_comb begin
    integ_n[0] = integ_q[0] + x;
    for (int k = 1; k < ORDER; k++) integ_n[k] = integ_q[k] + integ_n[k-1];
    comb_n[0] = integ_n[ORDER-1] - dly_q[0];
    for (int k = 1; k < ORDER; k++) comb_n[k] = comb_n[k-1] - dly_q[k];
  end

  assign word = comb_n[ORDER-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int k = 0; k < ORDER; k++) begin
        integ_q[k] <= '0;
        dly_q[k]   <= '0;
      end
    end else if (en) begin
      for (int k = 0; k < ORDER; k++) integ_q[k] <= integ_n[k];
      if (dump) begin
        dly_q[0] <= integ_n[ORDER-1];
        for (int k = 1; k < ORDER; k++) dly_q[k] <= comb_n[k-1];
      end
    end
  end

endmodule

// File: rtl/sinc1_core.sv
module sinc1_core #(
  parameter int NW = 8,
  parameter int AW = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 dump,
  input  logic                 x_bit,
  input  logic [NW-1:0]        n_act,
  output logic signed [AW-1:0] word
);
  logic signed [AW-1:0] x;
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_n;
  logic signed [AW-1:0] n_s;

  assign x     = x_bit ? AW'(1) : -AW'(1);
  assign acc_n = acc_q + x;
  assign n_s   = AW'(n_act);
  // Scale by N*N so full scale matches the third-order word.
  assign word  = acc_n * n_s * n_s;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= dump ? '0 : acc_n;
    end
  end

  AST_SINC1_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= n_s) && (acc_q >= -n_s))
    else $error("dump accumulator beyond one word"); // R4

endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator #(
  parameter  int NW = 8,
  localparam int AW = 1 + 3 * NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mod_valid,
  input  logic          mod_bit,
  input  logic [NW-1:0] decim_n,
  input  logic          fast_mode,
  input  logic          bypass,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_data
);
  import sinc_decim_pkg::*;

  logic [NW-1:0]        n_act;
  logic                 fast_act;
  logic                 restart;
  logic                 dump;
  logic                 word_ok;
  logic                 core_en;
  logic signed [AW-1:0] s3_word;
  logic signed [AW-1:0] s1_word;
  word_src_e            src;
  logic                 new_word;
  logic [AW-1:0]        next_data;

  sinc_word_timer #(.NW(NW)) timer_u (
    .clk(clk), .rst_n(rst_n), .sample_en(mod_valid),
    .decim_n(decim_n), .fast_mode(fast_mode),
    .n_act(n_act), .fast_act(fast_act), .restart(restart),
    .dump(dump), .word_ok(word_ok)
  );

  assign core_en = mod_valid && !restart;

  sinc3_core #(.AW(AW)) s3_u (
    .clk(clk), .rst_n(rst_n), .clr(restart), .en(core_en),
    .dump(dump), .x_bit(mod_bit), .word(s3_word)
  );

  sinc1_core #(.NW(NW), .AW(AW)) s1_u (
    .clk(clk), .rst_n(rst_n), .clr(restart), .en(core_en),
    .dump(dump), .x_bit(mod_bit), .n_act(n_act), .word(s1_word)
  );

  always_comb begin
    if (bypass && core_en)  src = SRC_RAW;
    else if (bypass)        src = SRC_NONE;
    else if (word_ok)       src = fast_act ? SRC_SINC1 : SRC_SINC3;
    else                    src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_RAW:   next_data = {{(AW-1){1'b0}}, mod_bit};
      SRC_SINC1: next_data = s1_word;
      SRC_SINC3: next_data = s3_word;
      default:   next_data = out_data;
    endcase
  end

  assign new_word = (src != SRC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (restart) begin
      out_valid <= 1'b0;
    end else if (new_word) begin
      out_valid <= 1'b1;
      out_data  <= next_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !new_word && !restart) |=> (out_valid && $stable(out_data)))
    else $error("unread word lost"); // R9

  AST_RESTART_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_valid) else $error("valid survived restart"); // R5

  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && mod_valid && !restart) |=>
      (out_valid && (out_data == {{(AW-1){1'b0}}, $past(mod_bit)})))
    else $error("raw bit not presented"); // R8

endmodule

// File: tb/sinc_decimator_tb_top.sv
module sinc_decimator_tb_top;
  localparam int NW = 6;
  localparam int AW = 1 + 3 * NW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mod_valid = 1'b0;
  logic          mod_bit = 1'b0;
  logic [NW-1:0] decim_n = NW'(4);
  logic          fast_mode = 1'b0;
  logic          bypass = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_data;

  always #2 clk = ~clk;

  sinc_decimator #(.NW(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mod_valid(mod_valid), .mod_bit(mod_bit),
    .decim_n(decim_n), .fast_mode(fast_mode), .bypass(bypass),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  int hist[$];
  int wt[256];
  int n_m = 4, cnt_m = 0, words_m = 0;
  bit fast_m = 0, byp_m = 0, pend_m = 0;
  int exp_m = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic int box3(input int n, input int j);
    int c = 0;
    for (int a = 0; a < n; a++)
      for (int b = 0; b < n; b++)
        if (j - a - b >= 0 && j - a - b < n) c++;
    return c;
  endfunction

  task automatic reload();
    for (int j = 0; j < 256; j++) wt[j] = (j <= 3 * n_m - 3) ? box3(n_m, j) : 0;
  endtask

  function automatic int model_word();
    int s = 0;
    int sz = hist.size();
    if (fast_m) begin
      for (int j = 0; j < n_m; j++) s += hist[sz-1-j];
      return s * n_m * n_m;
    end
    for (int j = 0; j <= 3 * n_m - 3; j++)
      if (sz - 1 - j >= 0) s += wt[j] * hist[sz-1-j];
    return s;
  endfunction

  function automatic int got_data();
    return int'($signed(out_data));
  endfunction

  // One clock: drive at negedge, check just after the posedge.
  task automatic cycle(input bit v, input bit b, input bit rdy, input string req);
    bit nw = 0;
    bit bnd = 0;
    @(negedge clk);
    mod_valid = v; mod_bit = b; out_ready = rdy;
    @(posedge clk); #1;
    if (v) begin
      hist.push_back(b ? 1 : -1);
      cnt_m++;
      if (cnt_m == n_m) begin
        cnt_m = 0;
        bnd = 1;
        if (words_m < 3) words_m++;
      end
      if (byp_m) begin
        nw = 1; exp_m = b;
      end else if (bnd && (fast_m ? words_m >= 1 : words_m >= 3)) begin
        nw = 1; exp_m = model_word();
      end
    end
    if (nw) pend_m = 1;
    else if (rdy) pend_m = 0;
    check(out_valid == pend_m, req, out_valid, pend_m);
    if (pend_m) check(got_data() == exp_m, req, got_data(), exp_m);
  endtask

  task automatic set_ctrl(input int n, input bit f, input bit byp);
    @(negedge clk);
    decim_n = NW'(n); fast_mode = f; bypass = byp; mod_valid = 0;
    @(posedge clk); #1;
    byp_m = byp;
    if (n != n_m || f != fast_m) begin
      hist.delete(); cnt_m = 0; words_m = 0; pend_m = 0;
      n_m = n; fast_m = f;
      reload();
    end else if (out_ready) begin
      pend_m = 0;
    end
    check(out_valid == pend_m, "R5", out_valid, pend_m);
  endtask

  // mode: 0 random, 1 all ones, 2 all zeros, 3 alternating
  task automatic run_words(input int nwd, input int mode, input string req, input int gap);
    for (int i = 0; i < nwd * n_m; i++) begin
      bit b;
      if (gap > 0) repeat ($urandom_range(0, gap)) cycle(0, 0, 1, req);
      case (mode)
        1: b = 1;
        2: b = 0;
        3: b = i[0];
        default: b = 1'($urandom_range(0, 1));
      endcase
      cycle(1, b, 1, req);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    reload();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(out_data == '0, "R1", got_data(), 0);
    rst_n = 1'b1;
    cycle(0, 0, 1, "R1");

    // Third-order settle and full scale at N=4
    run_words(3, 1, "R5", 0);
    check(got_data() == 64, "R3", got_data(), 64);
    run_words(6, 0, "R3", 2);

    // Fast mode: one-word settle, same full scale
    set_ctrl(4, 1, 0);
    run_words(1, 3, "R6", 0);
    check(got_data() == 0, "R7", got_data(), 0);
    run_words(1, 1, "R4", 0);
    check(got_data() == 64, "R4", got_data(), 64);
    run_words(6, 0, "R4", 2);

    // Back to third order: three-word settle
    set_ctrl(4, 0, 0);
    run_words(3, 0, "R5", 0);

    // Sweep of N, both orders
    foreach (wt[k]) if (k < 6) begin
      int nl;
      case (k) 0: nl = 2; 1: nl = 3; 2: nl = 5; 3: nl = 8; 4: nl = 17; default: nl = 63; endcase
      set_ctrl(nl, 1'($urandom_range(0, 1)), 0);
      run_words(4, 0, "R2", 1);
    end

    // Full scale at the largest N
    set_ctrl(63, 0, 0);
    run_words(3, 1, "R3", 0);
    check(got_data() == 250047, "R3", got_data(), 250047);
    run_words(3, 2, "R3", 0);
    check(got_data() == -250047, "R3", got_data(), -250047);

    // Restart in the middle of a word
    set_ctrl(5, 0, 0);
    cycle(1, 1, 1, "R5");
    cycle(1, 0, 1, "R5");
    set_ctrl(6, 0, 0);
    run_words(3, 0, "R5", 1);
    set_ctrl(6, 1, 0);
    cycle(1, 1, 1, "R7");
    set_ctrl(7, 1, 0);
    run_words(1, 0, "R7", 0);

    // Raw bypass, then filtered words resume on the same grid
    set_ctrl(6, 0, 1);
    for (int i = 0; i < 14; i++) cycle(1, 1'($urandom_range(0, 1)), 1, "R8");
    set_ctrl(6, 0, 0);
    run_words(3, 0, "R8", 0);

    // Back-pressure: hold, release, overwrite
    set_ctrl(3, 1, 0);
    for (int i = 0; i < 3; i++) cycle(1, 1, 0, "R9");
    repeat (3) cycle(0, 0, 0, "R9");
    cycle(0, 0, 1, "R9");
    for (int i = 0; i < 6; i++) cycle(1, 1'(i % 3 == 0), 0, "R9");
    repeat (2) cycle(0, 0, 0, "R9");
    cycle(0, 0, 1, "R9");

    // Long idle gaps between samples
    set_ctrl(8, 0, 0);
    run_words(5, 0, "R10", 5);

    // Mixed random traffic
    for (int it = 0; it < 20; it++) begin
      set_ctrl($urandom_range(2, 20), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 9) == 0));
      for (int i = 0; i < 4 * n_m; i++) begin
        if ($urandom_range(0, 3) == 0) cycle(0, 0, 1'($urandom_range(0, 1)), "R9");
        cycle(1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0), "R3");
      end
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule